// File: doc/BRIEF.md
# Reload Timer with Compare-Driven PWM Output

This block is an up-counting timer whose single output pin forms a pulse-width modulated waveform. While running, the counter climbs by one each clock. When it passes its all-ones value it either restarts from a programmable base value or, if base restart is switched off, wraps to zero. Each such wrap drives the output high. When the counter reaches a programmable compare value, the output goes low. The waveform period is therefore the all-ones wrap point minus the base, and the high time is the compare value minus the base.

Software drives the block through a small write port that selects one of three registers: base, compare and control. The two registers behave differently after a write. The base value is only read at a wrap, so a new base never disturbs the cycle in progress. The compare value is checked against the counter on every clock, so a new compare value acts at once. If the compare value is moved below the current count while the output is high, that pulse only ends at the compare point of the following cycle. That cycle is then stretched. The block reproduces this behaviour on purpose.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the count is 0, the output is low, all registers are 0 and the counter is stopped. While the run bit (control bit 0) is 0, the count and the output hold their values.
- R2: A control write that sets the run bit while the counter is stopped loads the count from the base register and drives the output low, both on the clock edge that applies the write.
- R3: While running with base restart enabled (control bit 1 = 1), the clock after the count is all-ones loads the count with the base register value.
- R4: While running with base restart disabled (control bit 1 = 0), the clock after the count is all-ones sets the count to 0.
- R5: With the wrap event enabled (control bit 2 = 1), every wrap drives the output high. With the compare event also on, the high time is compare minus base and the period is 2^CNT_W minus base, in clocks.
- R6: With the compare event enabled (control bit 3 = 1), the output goes low on the edge where the count takes the compare value.
- R7: A write to the base register (select 0) leaves the running count unchanged. The new base is used from the next wrap on.
- R8: A write to the compare register (select 1) takes effect on the next clock. A new value above the count while the output is high ends the current pulse at the new value. A write while the output is low does not disturb the current cycle.
- R9: A compare value written below the count while the output is high produces no fall in this cycle. The output stays high through the wrap and falls at the compare point of the next cycle.
- R10: When a wrap and a compare hit fall on the same edge (compare equal to base), the wrap takes priority and the output is high.
- R11: With both event enables at 0, the output holds its value while the counter runs.
- R12: Every write is applied on the clock edge at which it is presented with the write strobe. Select 2 writes the control register and select 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Register select: 0 base, 1 compare, 2 control, 3 none |
| wr_data | input | CNT_W | Write data. For control: bit0 run, bit1 base restart, bit2 wrap event, bit3 compare event |
| count_o | output | CNT_W | Current counter value |
| pwm_o | output | 1 | PWM output |

## Verification
The bench builds the timer with an 8-bit counter rather than the 32-bit default. A wrap then comes around within 256 clocks, so full periods, stretched pulses, wrap-to-zero and stop/restart sequences all fit in a few thousand cycles. A behavioural model follows the same writes and is compared against the count and the output on every clock. Mid-pulse compare writes are placed at chosen count values so that both the early-end case and the stretched-cycle case are hit exactly.

// File: rtl/pwm_tmr_pkg.sv
// Shared types for the reload PWM timer: write-select codes and control layout.
package pwm_tmr_pkg;

    typedef enum logic [1:0] {
        SEL_BASE    = 2'd0,
        SEL_CMP     = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_NONE    = 2'd3
    } wsel_e;

    // Control register, bit 0 = run ... bit 3 = compare event enable
    typedef struct packed {
        logic cmp_en;
        logic wrap_en;
        logic restart_en;
        logic run;
    } ctrl_t;

    localparam int CTRL_BITS = 4;

endpackage

// File: rtl/tmr_regs.sv
// Register file of the timer: base, compare and control.
// Assumes CNT_W >= CTRL_BITS. Writes land on the edge they are presented.
// Produces a start pulse when a control write turns the run bit on from stopped.
module tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] base_q,
    output logic [CNT_W-1:0] cmp_q,
    output ctrl_t            ctrl_q,
    output logic             start
);

    wsel_e sel;
    ctrl_t ctrl_wr;

    // Decode the select code and the control view of the data
    always_comb begin
        sel     = wsel_e'(wr_sel);
        ctrl_wr = ctrl_t'(wr_data[CTRL_BITS-1:0]);
        start   = wr_en && (sel == SEL_CTRL) && ctrl_wr.run && !ctrl_q.run;
    end

    // Register update on write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cmp_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_BASE: base_q <= wr_data;
                SEL_CMP:  cmp_q  <= wr_data;
                SEL_CTRL: ctrl_q <= ctrl_wr;
                default:  ;
            endcase
        end
    end

    AST_IGNORED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd3) |=> ($stable(base_q) && $stable(cmp_q) && $stable(ctrl_q))); // R12

endmodule

// File: rtl/tmr_counter.sv
// Up-counter with wrap detection. At all-ones it either reloads from the base
// register or returns to zero. A start pulse forces the base value in.
// Exposes the value the counter will take next, for the compare path.
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             restart_en,
    input  logic [CNT_W-1:0] base_q,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nxt,
    output logic             wrap
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    // Wrap detect and next-count selection
    always_comb begin
        wrap      = run && (count_q == TOP);
        count_nxt = wrap ? (restart_en ? base_q : '0) : count_q + 1'b1;
    end

    // Count register
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (start)
            count_q <= base_q;
        else if (run)
            count_q <= count_nxt;
    end

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !start) |=> $stable(count_q)); // R1
    AST_START_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (count_q == $past(base_q))); // R2
    AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && restart_en) |=> (count_q == $past(base_q))); // R3
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !restart_en) |=> (count_q == '0)); // R4

endmodule

// File: rtl/tmr_outgen.sv
// Output generator. A wrap sets the pin high, a compare hit sets it low,
// and the wrap wins when both happen on the same edge. The compare is checked
// against the next count, so the pin is high for exactly compare minus base clocks.
module tmr_outgen #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             start,
    input  logic             wrap,
    input  logic             wrap_en,
    input  logic             cmp_en,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic [CNT_W-1:0] cmp_q,
    output logic             pwm_q
);

    logic hit;
    logic set_hi;
    logic set_lo;

    // Event qualification
    always_comb begin
        hit    = run && (count_nxt == cmp_q);
        set_hi = wrap && wrap_en;
        set_lo = hit && cmp_en;
    end

    // Output register with wrap priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_q <= 1'b0;
        else if (start)
            pwm_q <= 1'b0;
        else if (set_hi)
            pwm_q <= 1'b1;
        else if (set_lo)
            pwm_q <= 1'b0;
    end

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !pwm_q); // R2
    AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && wrap_en) |=> pwm_q); // R5
    AST_CMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (set_lo && !wrap) |=> !pwm_q); // R6
    AST_BOTH_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && wrap_en && hit) |=> pwm_q); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !set_hi && !set_lo) |=> $stable(pwm_q)); // R11

endmodule

// File: rtl/pwm_reload_timer.sv
// Top of the reload PWM timer: register file, counter and output generator.
// Assumes a single clock and synchronous active-low reset.
module pwm_reload_timer
    import pwm_tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] count_o,
    output logic             pwm_o
);

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] count_nxt;
    ctrl_t            ctrl_q;
    logic             start;
    logic             wrap;

    tmr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .base_q  (base_q),
        .cmp_q   (cmp_q),
        .ctrl_q  (ctrl_q),
        .start   (start)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (ctrl_q.run),
        .start      (start),
        .restart_en (ctrl_q.restart_en),
        .base_q     (base_q),
        .count_q    (count_o),
        .count_nxt  (count_nxt),
        .wrap       (wrap)
    );

    tmr_outgen #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (ctrl_q.run),
        .start     (start),
        .wrap      (wrap),
        .wrap_en   (ctrl_q.wrap_en),
        .cmp_en    (ctrl_q.cmp_en),
        .count_nxt (count_nxt),
        .cmp_q     (cmp_q),
        .pwm_q     (pwm_o)
    );

endmodule

// File: tb/pwm_reload_timer_test.sv
// Bench for the reload PWM timer: behavioural model compared on every clock,
// plus directed measurements of pulse and period lengths.
module pwm_reload_timer_test;

    localparam int W    = 8;
    localparam int MAXV = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] count_o;
    logic         pwm_o;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string cur_req = "R1";

    // model state
    int m_cnt = 0, m_base = 0, m_cmp = 0;
    bit m_pwm = 0, m_run = 0, m_rst = 0, m_wen = 0, m_cen = 0;

    pwm_reload_timer #(.CNT_W(W)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .count_o (count_o),
        .pwm_o   (pwm_o)
    );

    always #4 clk = ~clk;

    // Behavioural model, stepped once per rising edge
    always @(posedge clk) begin
        int nxt;
        bit wrp;
        if (!rst_n) begin
            m_cnt = 0; m_base = 0; m_cmp = 0; m_pwm = 0;
            m_run = 0; m_rst = 0; m_wen = 0; m_cen = 0;
        end else begin
            wrp = m_run && (m_cnt == MAXV);
            nxt = wrp ? (m_rst ? m_base : 0) : m_cnt + 1;
            if (wr_en && wr_sel == 2'd2 && wr_data[0] && !m_run) begin
                m_cnt = m_base;
                m_pwm = 0;
            end else if (m_run) begin
                if (wrp && m_wen) m_pwm = 1;
                else if (nxt == m_cmp && m_cen) m_pwm = 0;
                m_cnt = nxt;
            end
            if (wr_en) begin
                if (wr_sel == 2'd0) m_base = int'(wr_data);
                else if (wr_sel == 2'd1) m_cmp = int'(wr_data);
                else if (wr_sel == 2'd2) begin
                    m_run = wr_data[0]; m_rst = wr_data[1];
                    m_wen = wr_data[2]; m_cen = wr_data[3];
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(count_o) == m_cnt, {cur_req, " count"}, int'(count_o), m_cnt);
            check(pwm_o == m_pwm, {cur_req, " output"}, int'(pwm_o), int'(m_pwm));
        end
    end

    // Watchdog
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] s, input int d);
        wr_en = 1'b1; wr_sel = s; wr_data = W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_rise();
        bit prev = pwm_o;
        forever begin
            @(negedge clk);
            if (!prev && pwm_o) return;
            prev = pwm_o;
        end
    endtask

    task automatic wait_count(input int v);
        while (int'(count_o) != v) @(negedge clk);
    endtask

    // Measure one period and its high time, rise to rise
    task automatic measure(output int hi, output int per);
        bit prev;
        wait_rise();
        hi = 1; per = 1; prev = 1'b1;
        forever begin
            @(negedge clk);
            if (!prev && pwm_o) return;
            prev = pwm_o;
            per++;
            if (pwm_o) hi++;
        end
    endtask

    // High time of one pulse with a compare write at a chosen count
    task automatic pulse_write(input int trig, input int newc, output int hi);
        bit done = 0;
        wait_rise();
        hi = 1;
        forever begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!done && int'(count_o) == trig) begin
                wr_en = 1'b1; wr_sel = 2'd1; wr_data = W'(newc); done = 1;
            end
            if (pwm_o) hi++;
            else begin
                wr_en = 1'b0;
                return;
            end
        end
    endtask

    initial begin
        int hi, per, lows;
        int held;
        repeat (3) @(negedge clk);
        check(count_o == '0 && pwm_o == 1'b0, "R1 reset", int'(count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        cur_req = "R12";
        wr(2'd0, 'hC0);
        wr(2'd1, 'hE0);
        cur_req = "R2";
        wr(2'd2, 'hF);
        check(int'(count_o) == 'hC0, "R2 start count", int'(count_o), 'hC0);
        check(pwm_o == 1'b0, "R2 start low", int'(pwm_o), 0);

        cur_req = "R5";
        measure(hi, per);
        check(per == 64, "R5 period", per, 64);
        check(hi == 32, "R6 high time", hi, 32);

        cur_req = "R7";
        wait_count('hD0);
        wr(2'd0, 'h80);
        check(int'(count_o) == 'hD1, "R7 count undisturbed", int'(count_o), 'hD1);
        measure(hi, per);
        check(per == 128, "R7 new period", per, 128);
        check(hi == 96, "R7 new high", hi, 96);

        cur_req = "R8";
        pulse_write('h90, 'hC0, hi);
        check(hi == 64, "R8 early end", hi, 64);
        wr(2'd1, 'hE0);
        check(pwm_o == 1'b0, "R8 write while low", int'(pwm_o), 0);

        cur_req = "R9";
        pulse_write('hD0, 'h90, hi);
        check(hi == 144, "R9 stretched high", hi, 144);

        cur_req = "R10";
        wr(2'd1, 'h80);
        wait_rise();
        check(int'(count_o) == 'h80, "R3 reload value", int'(count_o), 'h80);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!pwm_o) lows++;
        end
        check(lows == 0, "R10 wrap wins", lows, 0);

        cur_req = "R11";
        wr(2'd1, 'hE0);
        wr(2'd2, 'h3);
        lows = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!pwm_o) lows++;
        end
        check(lows == 0, "R11 output held", lows, 0);

        cur_req = "R4";
        wr(2'd2, 'hD);
        wait_count(MAXV);
        @(negedge clk);
        check(int'(count_o) == 0, "R4 wrap to zero", int'(count_o), 0);
        check(pwm_o == 1'b1, "R5 high after wrap", int'(pwm_o), 1);
        repeat (20) @(negedge clk);

        cur_req = "R1";
        wr(2'd2, 'h0);
        held = int'(count_o);
        repeat (20) @(negedge clk);
        check(int'(count_o) == held, "R1 stopped hold", int'(count_o), held);

        cur_req = "R12";
        wr(2'd3, 'hF);
        repeat (5) @(negedge clk);
        check(int'(count_o) == held, "R12 select 3 ignored", int'(count_o), held);
        wr(2'd2, 'hF);
        check(int'(count_o) == 'h80, "R2 restart from base", int'(count_o), 'h80);
        cur_req = "R3";
        repeat (300) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule